// File: doc/BRIEF.md
# Overflow-Trapping Integer Add/Subtract Unit

This unit runs the trapping forms of integer addition and subtraction for a core with 64-bit general registers. Each operation is chosen by a 3-bit opcode. It takes two register operands or a register and a 16-bit immediate, and works at either word (32-bit) or doubleword (64-bit) width. A word operation looks only at the low half of each operand. Its 32-bit result is sign-extended before it goes to the destination.

When the signed result does not fit at the operation width, the unit does not enable the destination write. It raises an overflow exception request instead. That request carries the program counter of the instruction that caused it. All outputs are registered, so a request presented with `in_valid` shows its outcome on the following cycle. Exception vectoring and hazard handling belong to the surrounding pipeline.

Top module: `ovf_trap_alu`

## Requirements
- R1: While reset is held, and in the first cycle after it, `out_valid`, `out_wr_en` and `out_exc` are 0, and `out_result` and `out_exc_pc` are all zeros.
- R2: `out_valid` is 1 exactly in the cycle after a cycle in which `in_valid` was 1 (one-cycle latency).
- R3: Word forms (opcodes 0, 1, 4) use only bits 31:0 of the operands. The 32-bit result is written with bit 31 copied into bits 63:32. Bits 63:32 of the inputs have no effect on the outcome.
- R4: Doubleword forms (opcodes 2, 3, 5) add or subtract the full 64-bit operands and write the 64-bit result.
- R5: Immediate forms (opcode 1 at word width, opcode 3 at doubleword width) take the place of `in_b` with `in_imm` sign-extended from bit 15.
- R6: An addition overflows when both operands have the same sign at the operation width and the result's sign differs from it. A subtraction a minus b overflows when the operands' signs differ and the result's sign differs from a's.
- R7: On overflow of a legal valid operation, `out_exc` is 1, `out_wr_en` is 0, and `out_exc_pc` equals the `in_pc` presented with that operation.
- R8: `out_wr_en` and `out_exc` are never 1 together. Both are 0 whenever `out_valid` is 0.
- R9: Opcode encoding: 0 add word, 1 add-immediate word, 2 add doubleword, 3 add-immediate doubleword, 4 subtract word, 5 subtract doubleword. Codes 6 and 7 give `out_valid` 1 with neither write nor exception.
- R10: `out_result` is all zeros whenever `out_wr_en` is 0. `out_exc_pc` is all zeros whenever `out_exc` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| in_op | input | 3 | Opcode select |
| in_a | input | 64 | First register operand |
| in_b | input | 64 | Second register operand |
| in_imm | input | 16 | Immediate field |
| in_pc | input | 64 | Program counter of the instruction |
| out_valid | output | 1 | Outcome present this cycle |
| out_result | output | 64 | Value for the destination register |
| out_wr_en | output | 1 | Destination write enable |
| out_exc | output | 1 | Overflow exception request |
| out_exc_pc | output | 64 | Program counter of the faulting instruction |

## Verification
Directed operands sit on the signed boundaries of each width: maximum plus one, minimum minus one, and the pairs just short of them. Together these separate a correct overflow rule from one that uses the wrong bit or the wrong sign test for subtraction. Word cases carry junk in the upper operand halves and an immediate of 0xFFFF or 0x8000. This exposes a missing sign extension and any leakage from bits 63:32. Random opcodes, including 6 and 7, run with operands biased toward the extremes and with idle cycles mixed in. This checks the write/exception exclusion, the zeroed outputs and the carried program counter against a model that detects overflow from a result one bit wider.

// File: rtl/ovf_pkg.sv
package ovf_pkg;

    parameter int XLEN  = 64;
    parameter int WLEN  = 32;
    parameter int IMM_W = 16;
    parameter int OP_W  = 3;

    localparam logic [OP_W-1:0] OP_ADD_W  = 3'd0;
    localparam logic [OP_W-1:0] OP_ADDI_W = 3'd1;
    localparam logic [OP_W-1:0] OP_ADD_D  = 3'd2;
    localparam logic [OP_W-1:0] OP_ADDI_D = 3'd3;
    localparam logic [OP_W-1:0] OP_SUB_W  = 3'd4;
    localparam logic [OP_W-1:0] OP_SUB_D  = 3'd5;

    typedef struct packed {
        logic legal;
        logic is_sub;
        logic is_word;
        logic use_imm;
    } alu_ctrl_t;

    typedef struct packed {
        logic            valid;
        logic            wr_en;
        logic            exc;
        logic [XLEN-1:0] result;
        logic [XLEN-1:0] pc;
    } alu_resp_t;

    function automatic logic [XLEN-1:0] sext_word(input logic [WLEN-1:0] w);
        return {{(XLEN-WLEN){w[WLEN-1]}}, w};
    endfunction

    function automatic logic [XLEN-1:0] sext_imm(input logic [IMM_W-1:0] i);
        return {{(XLEN-IMM_W){i[IMM_W-1]}}, i};
    endfunction

endpackage

// File: rtl/ovf_decode.sv
module ovf_decode
    import ovf_pkg::*;
(
    input  logic [OP_W-1:0] op,
    output alu_ctrl_t       ctrl
);
    always_comb begin
        ctrl = '0;
        unique case (op)
            OP_ADD_W:  ctrl = '{legal: 1'b1, is_sub: 1'b0, is_word: 1'b1, use_imm: 1'b0};
            OP_ADDI_W: ctrl = '{legal: 1'b1, is_sub: 1'b0, is_word: 1'b1, use_imm: 1'b1};
            OP_ADD_D:  ctrl = '{legal: 1'b1, is_sub: 1'b0, is_word: 1'b0, use_imm: 1'b0};
            OP_ADDI_D: ctrl = '{legal: 1'b1, is_sub: 1'b0, is_word: 1'b0, use_imm: 1'b1};
            OP_SUB_W:  ctrl = '{legal: 1'b1, is_sub: 1'b1, is_word: 1'b1, use_imm: 1'b0};
            OP_SUB_D:  ctrl = '{legal: 1'b1, is_sub: 1'b1, is_word: 1'b0, use_imm: 1'b0};
            default:   ctrl = '0;
        endcase
    end
endmodule

// File: rtl/ovf_addsub.sv
module ovf_addsub
    import ovf_pkg::*;
(
    input  alu_ctrl_t        ctrl,
    input  logic [XLEN-1:0]  a,
    input  logic [XLEN-1:0]  b,
    input  logic [IMM_W-1:0] imm,
    output logic [XLEN-1:0]  result,
    output logic             ovf
);
    logic [XLEN-1:0] opnd_a;
    logic [XLEN-1:0] opnd_b;
    logic [XLEN-1:0] b_sel;
    logic [XLEN-1:0] raw;
    logic [XLEN-1:0] flag_vec;

    always_comb begin
        b_sel  = ctrl.use_imm ? sext_imm(imm) : b;
        // word forms: widen the low half so a single 64-bit adder serves both widths
        opnd_a = ctrl.is_word ? sext_word(a[WLEN-1:0])     : a;
        opnd_b = ctrl.is_word ? sext_word(b_sel[WLEN-1:0]) : b_sel;
        raw    = ctrl.is_sub ? (opnd_a - opnd_b) : (opnd_a + opnd_b);
        result = ctrl.is_word ? sext_word(raw[WLEN-1:0]) : raw;
        if (ctrl.is_sub)
            flag_vec = (opnd_a ^ opnd_b) & (opnd_a ^ result);
        else
            flag_vec = ~(opnd_a ^ opnd_b) & (opnd_a ^ result);
        ovf = ctrl.is_word ? flag_vec[WLEN-1] : flag_vec[XLEN-1];
    end
endmodule

// File: rtl/ovf_outreg.sv
module ovf_outreg
    import ovf_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  alu_resp_t d,
    output alu_resp_t q
);
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    p_result_zero_r10: assert property (@(posedge clk) disable iff (rst)
        !q.wr_en |-> (q.result == '0));
    p_pc_zero_r10: assert property (@(posedge clk) disable iff (rst)
        !q.exc |-> (q.pc == '0));
endmodule

// File: rtl/ovf_trap_alu.sv
module ovf_trap_alu
    import ovf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [OP_W-1:0]  in_op,
    input  logic [XLEN-1:0]  in_a,
    input  logic [XLEN-1:0]  in_b,
    input  logic [IMM_W-1:0] in_imm,
    input  logic [XLEN-1:0]  in_pc,
    output logic             out_valid,
    output logic [XLEN-1:0]  out_result,
    output logic             out_wr_en,
    output logic             out_exc,
    output logic [XLEN-1:0]  out_exc_pc
);
    alu_ctrl_t       ctrl;
    logic [XLEN-1:0] sum;
    logic            ovf;
    alu_resp_t       resp_d;
    alu_resp_t       resp_q;

    ovf_decode u_dec (.op(in_op), .ctrl(ctrl));

    ovf_addsub u_arith (
        .ctrl(ctrl), .a(in_a), .b(in_b), .imm(in_imm),
        .result(sum), .ovf(ovf)
    );

    always_comb begin
        resp_d        = '0;
        resp_d.valid  = in_valid;
        resp_d.wr_en  = in_valid && ctrl.legal && !ovf;
        resp_d.exc    = in_valid && ctrl.legal && ovf;
        resp_d.result = resp_d.wr_en ? sum : '0;
        resp_d.pc     = resp_d.exc ? in_pc : '0;
    end

    ovf_outreg u_oreg (.clk(clk), .rst(rst), .d(resp_d), .q(resp_q));

    assign out_valid  = resp_q.valid;
    assign out_wr_en  = resp_q.wr_en;
    assign out_exc    = resp_q.exc;
    assign out_result = resp_q.result;
    assign out_exc_pc = resp_q.pc;

    p_excl_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({out_wr_en, out_exc}));
    p_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (!out_wr_en && !out_exc));
    p_latency_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));
    p_latency_fwd_r2: assert property (@(posedge clk) disable iff (rst)
        ($past(in_valid) && !$past(rst)) |-> out_valid);
    p_exc_pc_r7: assert property (@(posedge clk) disable iff (rst)
        out_exc |-> (out_exc_pc == $past(in_pc)));
    p_sext_r3: assert property (@(posedge clk) disable iff (rst)
        (out_wr_en && $past(ctrl.is_word))
            |-> (out_result[XLEN-1:WLEN] == {(XLEN-WLEN){out_result[WLEN-1]}}));
endmodule

// File: tb/ovf_trap_alu_test.sv
module ovf_trap_alu_test;
    import ovf_pkg::*;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic [2:0]       in_op = '0;
    logic [63:0]      in_a = '0;
    logic [63:0]      in_b = '0;
    logic [15:0]      in_imm = '0;
    logic [63:0]      in_pc = '0;
    logic             out_valid;
    logic [63:0]      out_result;
    logic             out_wr_en;
    logic             out_exc;
    logic [63:0]      out_exc_pc;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    ovf_trap_alu uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_a(in_a), .in_b(in_b), .in_imm(in_imm), .in_pc(in_pc),
        .out_valid(out_valid), .out_result(out_result), .out_wr_en(out_wr_en),
        .out_exc(out_exc), .out_exc_pc(out_exc_pc)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // independent model: overflow from a result one bit wider than the width
    task automatic model(input logic [2:0] op, input logic [63:0] a, input logic [63:0] b,
                         input logic [15:0] imm, output logic wr, output logic exc,
                         output logic [63:0] res);
        logic [63:0] bb;
        logic [32:0] w;
        logic [64:0] d;
        logic        sub;
        wr = 0; exc = 0; res = '0;
        bb  = (op == 3'd1 || op == 3'd3) ? {{48{imm[15]}}, imm} : b;
        sub = (op == 3'd4 || op == 3'd5);
        if (op == 3'd0 || op == 3'd1 || op == 3'd4) begin
            w = sub ? ({a[31], a[31:0]} - {bb[31], bb[31:0]})
                    : ({a[31], a[31:0]} + {bb[31], bb[31:0]});
            if (w[32] != w[31]) exc = 1;
            else begin wr = 1; res = {{32{w[31]}}, w[31:0]}; end
        end else if (op == 3'd2 || op == 3'd3 || op == 3'd5) begin
            d = sub ? ({a[63], a} - {bb[63], bb}) : ({a[63], a} + {bb[63], bb});
            if (d[64] != d[63]) exc = 1;
            else begin wr = 1; res = d[63:0]; end
        end
    endtask

    task automatic run_op(input string req, input logic [2:0] op, input logic [63:0] a,
                          input logic [63:0] b, input logic [15:0] imm, input logic [63:0] pc);
        logic ewr, eexc;
        logic [63:0] eres;
        model(op, a, b, imm, ewr, eexc, eres);
        @(negedge clk);
        in_valid = 1; in_op = op; in_a = a; in_b = b; in_imm = imm; in_pc = pc;
        @(posedge clk); #5;
        in_valid = 0;
        chk("R2", "valid", {63'd0, out_valid}, 64'd1);
        chk(req, "wr_en", {63'd0, out_wr_en}, {63'd0, ewr});
        chk(req, "exc", {63'd0, out_exc}, {63'd0, eexc});
        chk(req, "result", out_result, eres);
        chk("R7", "exc_pc", out_exc_pc, eexc ? pc : 64'd0);
    endtask

    function automatic logic [63:0] pick64();
        case ($urandom % 6)
            0: return 64'h7FFF_FFFF_FFFF_FFFF - 64'($urandom % 4);
            1: return 64'h8000_0000_0000_0000 + 64'($urandom % 4);
            2: return {$urandom, 32'h7FFF_FFFF - 32'($urandom % 4)};
            3: return {$urandom, 32'h8000_0000 + 32'($urandom % 4)};
            default: return {$urandom, $urandom};
        endcase
    endfunction

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #5;
        chk("R1", "valid in reset", {63'd0, out_valid}, 64'd0);
        chk("R1", "result in reset", out_result, 64'd0);
        @(negedge clk); rst = 0;
        @(posedge clk); #5;
        chk("R1", "wr after reset", {63'd0, out_wr_en}, 64'd0);
        chk("R1", "exc after reset", {63'd0, out_exc}, 64'd0);
        chk("R1", "pc after reset", out_exc_pc, 64'd0);

        // R3 word add boundaries, junk upper halves
        run_op("R3", 3'd0, 64'hDEAD_0000_7FFF_FFFF, 64'h1234_5678_0000_0001, 16'h0, 64'h1000);
        run_op("R3", 3'd0, 64'hDEAD_0000_7FFF_FFFE, 64'hFFFF_0000_0000_0001, 16'h0, 64'h1004);
        run_op("R3", 3'd0, 64'h0000_0000_8000_0000, 64'h0000_0000_8000_0000, 16'h0, 64'h1008);
        // R4 doubleword add
        run_op("R4", 3'd2, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 16'h0, 64'h2000);
        run_op("R4", 3'd2, 64'h0000_0000_7FFF_FFFF, 64'd1, 16'h0, 64'h2004);
        // R5 immediates
        run_op("R5", 3'd1, 64'hAAAA_5555_8000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 16'hFFFF, 64'h3000);
        run_op("R5", 3'd1, 64'h0000_0000_0000_0005, 64'd0, 16'hFFFF, 64'h3004);
        run_op("R5", 3'd3, 64'h8000_0000_0000_7FFF, 64'd0, 16'h8000, 64'h3008);
        run_op("R5", 3'd3, 64'h8000_0000_0000_0000, 64'd0, 16'h8000, 64'h300C);
        // R6 subtraction rule
        run_op("R6", 3'd4, 64'h0000_0000_8000_0000, 64'd1, 16'h0, 64'h4000);
        run_op("R6", 3'd4, 64'h0000_0000_7FFF_FFFF, 64'h0000_0000_FFFF_FFFF, 16'h0, 64'h4004);
        run_op("R6", 3'd5, 64'h8000_0000_0000_0000, 64'd1, 16'h0, 64'h4008);
        run_op("R6", 3'd5, 64'hFFFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF, 16'h0, 64'h400C);
        // R9 unused codes
        run_op("R9", 3'd6, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 16'h0, 64'h5000);
        run_op("R9", 3'd7, 64'd3, 64'd4, 16'h0, 64'h5004);

        // R8 idle cycle
        @(negedge clk); in_valid = 0; in_op = 3'd0; in_a = 64'h7FFF_FFFF; in_b = 64'd1;
        @(posedge clk); #5;
        chk("R8", "idle valid", {63'd0, out_valid}, 64'd0);
        chk("R8", "idle wr", {63'd0, out_wr_en}, 64'd0);
        chk("R8", "idle exc", {63'd0, out_exc}, 64'd0);
        chk("R10", "idle result", out_result, 64'd0);

        for (int i = 0; i < 400; i++) begin
            logic [2:0] op;
            op = 3'($urandom % 8);
            run_op("R6", op, pick64(), pick64(), 16'($urandom), {$urandom, $urandom});
            if ($urandom % 5 == 0) begin
                @(negedge clk); in_valid = 0;
                @(posedge clk); #5;
                chk("R8", "gap valid", {63'd0, out_valid}, 64'd0);
                chk("R8", "gap flags", {62'd0, out_wr_en, out_exc}, 64'd0);
            end
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule